// File: doc/BRIEF.md
# Time-Division-Multiplexed Serial Receiver

This block receives a serial stream that is split into frames of `SLOTS` time slots, each carrying one `SLOT_W`-bit word. An external bit clock and a frame sync come in as plain inputs. A fast system clock oversamples them. Each falling edge of the bit clock is a bit event, and on that event the data pin is shifted in, most significant bit first. When the last bit of a slot arrives, the finished word can be written into a receive FIFO. This happens only if the receiver is running and that slot's mask bit is set.

Starting and stopping follow bit-position rules. A receive enable seen early in a slot includes that slot in reception. An enable seen late waits for the next slot. Clearing the receive enable lets the current frame finish. Clearing the global enable stops capture at once. In two-channel mode, captured words are steered alternately into two FIFOs. Both FIFOs have a show-ahead read port, a fill level, a full flag and a ready flag driven by a watermark. A sticky overrun flag records any word that found its FIFO full.

Top module: `tdm_net_rx`

## Requirements
- R1: Words are captured only while `glb_en` is 1. At the clock edge where `glb_en` is sampled 0, the receiver stops at once, and no word is captured until a later start under R3.
- R2: A bit event is a bit-clock fall (`bclk` 1 in one system cycle, 0 in the next). The event on which `fsync` is 1 carries the most significant bit of slot 0. Bits arrive MSB first, every `SLOT_W` events end a slot, and the slot count wraps to 0 after slot `SLOTS-1`.
- R3: A stopped receiver with `glb_en` and `rx_en` both 1 starts on a bit event whose position within the slot is at most `SLOT_W-3`, and that slot is captured. A position of `SLOT_W-2` or `SLOT_W-1` defers the start to the first bit of the next slot.
- R4: If `rx_en` is 0 while the receiver runs, every remaining slot of the current frame is still captured. The receiver stops after the last bit of slot `SLOTS-1`.
- R5: Slot s is captured only when `slot_mask[s]` is 1.
- R6: With `two_ch` at 0, every captured word goes to FIFO 0, and the level of FIFO 1 never rises.
- R7: With `two_ch` at 1, the first word after a start goes to FIFO 0, and later words alternate between FIFO 1 and FIFO 0. A dropped word also advances the alternation. A stop followed by a start goes back to FIFO 0.
- R8: A word whose target FIFO is full at the capture edge is discarded, even if a read happens in the same cycle. The FIFO contents and level stay unchanged, and `ovr` becomes 1 and stays 1.
- R9: A 1 on `ovr_clr` clears `ovr` at the next edge, unless a new overrun happens in that same cycle, in which case `ovr` stays 1.
- R10: `rd_data[c]` shows the oldest word of FIFO c, or 0 when the FIFO is empty. A 1 on `rd_en[c]` removes one word. A read of an empty FIFO changes nothing. `rx_level[c]` gives the word count, and `rx_full[c]` is 1 at `DEPTH` words.
- R11: `rx_rdy[c]` is 1 exactly when the level is at least `wmark`, with a `wmark` of 0 treated as 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk | input | 1 | External bit clock |
| fsync | input | 1 | Frame sync, high on the first bit of slot 0 |
| sdata | input | 1 | Serial data pin |
| glb_en | input | 1 | Global enable |
| rx_en | input | 1 | Receive enable |
| two_ch | input | 1 | 1 steers words alternately to two FIFOs |
| slot_mask | input | SLOTS | Per-slot capture select, bit s for slot s |
| wmark | input | CW | Ready watermark for both FIFOs |
| rd_en | input | 2 | Read strobe per FIFO |
| rd_data | output | 2 x SLOT_W | Head word per FIFO |
| rx_level | output | 2 x CW | Fill level per FIFO |
| rx_full | output | 2 | FIFO full per FIFO |
| rx_rdy | output | 2 | Level at or above the watermark |
| ovr_clr | input | 1 | Write-one clear of the overrun flag |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The bench builds the block with 8-bit slots, 4 slots per frame and FIFOs 4 words deep, with both channels present. At these sizes a single frame fills a FIFO, so overrun and the drop-with-read corner need only two frames. Bit positions 5 and 6 sit on either side of the start rule, so the early and late enable cases are each one frame long. With an odd mask of three slots, the two-channel alternation carries over a frame boundary, which shows both the continued alternation and its reset on restart.

// File: rtl/tdm_rx_pkg.sv
package tdm_rx_pkg;
   // channel select encoding used by the steering logic
   typedef enum logic {
      CH_A = 1'b0,
      CH_B = 1'b1
   } rx_ch_e;

   // index width for a count of n items, at least one bit
   function automatic int unsigned idx_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/tdm_rx_timing.sv
module tdm_rx_timing #(
   parameter int unsigned SLOT_W = 16,
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned PW     = 4,
   parameter int unsigned SW     = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk,
   input  logic          fsync,
   output logic          tick,
   output logic [PW-1:0] pos_cur,
   output logic [SW-1:0] slot_cur,
   output logic          last_bit,
   output logic          frame_end
);
   localparam logic [PW-1:0] POS_LAST  = PW'(SLOT_W - 1);
   localparam logic [SW-1:0] SLOT_LAST = SW'(SLOTS - 1);

   logic          bclk_q;
   logic [PW-1:0] pos_q;
   logic [SW-1:0] slot_q;

   // falling bit-clock edge seen in the system domain
   assign tick      = bclk_q & ~bclk;
   assign pos_cur   = fsync ? '0 : pos_q;
   assign slot_cur  = fsync ? '0 : slot_q;
   assign last_bit  = (pos_cur == POS_LAST);
   assign frame_end = last_bit && (slot_cur == SLOT_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bclk_q <= 1'b0;
         pos_q  <= '0;
         slot_q <= '0;
      end else begin
         bclk_q <= bclk;
         if (tick) begin
            if (last_bit) begin
               pos_q  <= '0;
               slot_q <= (slot_cur == SLOT_LAST) ? '0 : slot_cur + 1'b1;
            end else begin
               pos_q  <= pos_cur + 1'b1;
               slot_q <= slot_cur;
            end
         end
      end
   end
endmodule

// File: rtl/tdm_rx_shift.sv
module tdm_rx_shift #(
   parameter int unsigned SLOT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              sdata,
   output logic [SLOT_W-1:0] word
);
   logic [SLOT_W-1:0] sr_q;

   // the word including the bit arriving on this event
   assign word = {sr_q[SLOT_W-2:0], sdata};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sr_q <= '0;
      end else if (tick) begin
         sr_q <= word;
      end
   end
endmodule

// File: rtl/tdm_rx_ctrl.sv
module tdm_rx_ctrl
   import tdm_rx_pkg::*;
#(
   parameter int unsigned SLOT_W = 16,
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned PW     = 4,
   parameter int unsigned SW     = 3,
   parameter bit          DUAL   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             glb_en,
   input  logic             rx_en,
   input  logic             two_ch,
   input  logic [SLOTS-1:0] slot_mask,
   input  logic             tick,
   input  logic [PW-1:0]    pos_cur,
   input  logic [SW-1:0]    slot_cur,
   input  logic             last_bit,
   input  logic             frame_end,
   input  logic [1:0]       full,
   input  logic             ovr_clr,
   output logic [1:0]       push,
   output logic             ovr
);
   // latest bit position at which a start still includes the slot
   localparam logic [PW-1:0] POS_START = PW'(SLOT_W - 3);

   logic   run_q;
   rx_ch_e sel_q;
   logic   capture;
   logic   drop;
   logic   steer;
   rx_ch_e tgt;

   generate
      if (DUAL) begin : g_dual
         assign steer = two_ch;
      end else begin : g_single
         assign steer = 1'b0;
      end
   endgenerate

   assign capture = tick && last_bit && run_q && glb_en && slot_mask[slot_cur];
   assign tgt     = steer ? sel_q : CH_A;
   assign drop    = capture && full[tgt];
   assign push[0] = capture && (tgt == CH_A) && !full[0];
   assign push[1] = capture && (tgt == CH_B) && !full[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr <= 1'b0;
      end else if (drop) begin
         ovr <= 1'b1;
      end else if (ovr_clr) begin
         ovr <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b0;
         sel_q <= CH_A;
      end else if (!glb_en) begin
         run_q <= 1'b0;
         sel_q <= CH_A;
      end else if (run_q) begin
         if (tick && frame_end && !rx_en) begin
            run_q <= 1'b0;
            sel_q <= CH_A;
         end else if (capture && steer) begin
            sel_q <= (sel_q == CH_A) ? CH_B : CH_A;
         end
      end else if (rx_en && tick && (pos_cur <= POS_START)) begin
         run_q <= 1'b1;
         sel_q <= CH_A;
      end
   end
endmodule

// File: rtl/tdm_rx_fifo.sv
module tdm_rx_fifo #(
   parameter int unsigned WIDTH = 16,
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 3,
   parameter int unsigned CW    = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop_req,
   input  logic [CW-1:0]    wmark,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    level,
   output logic             full,
   output logic             rdy
);
   localparam logic [CW-1:0] LVL_MAX = CW'(DEPTH);

   logic [WIDTH-1:0] mem_q [DEPTH];
   logic [AW-1:0]    wr_q;
   logic [AW-1:0]    rd_q;
   logic             pop;
   logic             wr_ok;
   logic [CW-1:0]    wm_eff;

   assign full   = (level == LVL_MAX);
   assign pop    = pop_req && (level != '0);
   assign wr_ok  = push && !full;
   assign dout   = (level != '0) ? mem_q[rd_q] : '0;
   assign wm_eff = (wmark == '0) ? CW'(1) : wmark;
   assign rdy    = (level >= wm_eff);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_q  <= '0;
         rd_q  <= '0;
         level <= '0;
      end else begin
         if (wr_ok) wr_q <= wr_q + 1'b1;
         if (pop)   rd_q <= rd_q + 1'b1;
         if (wr_ok && !pop)      level <= level + 1'b1;
         else if (pop && !wr_ok) level <= level - 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_ok) mem_q[wr_q] <= din;
   end
endmodule

// File: rtl/tdm_net_rx.sv
module tdm_net_rx
   import tdm_rx_pkg::*;
#(
   parameter int unsigned SLOT_W = 16,
   parameter int unsigned SLOTS  = 8,
   parameter int unsigned DEPTH  = 8,
   parameter bit          DUAL   = 1'b1,
   localparam int unsigned CW    = $clog2(DEPTH + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bclk,
   input  logic                  fsync,
   input  logic                  sdata,
   input  logic                  glb_en,
   input  logic                  rx_en,
   input  logic                  two_ch,
   input  logic [SLOTS-1:0]      slot_mask,
   input  logic [CW-1:0]         wmark,
   input  logic [1:0]            rd_en,
   output logic [1:0][SLOT_W-1:0] rd_data,
   output logic [1:0][CW-1:0]    rx_level,
   output logic [1:0]            rx_full,
   output logic [1:0]            rx_rdy,
   input  logic                  ovr_clr,
   output logic                  ovr
);
   localparam int unsigned PW  = idx_bits(SLOT_W);
   localparam int unsigned SW  = idx_bits(SLOTS);
   localparam int unsigned AW  = idx_bits(DEPTH);
   localparam int unsigned NCH = DUAL ? 2 : 1;

   initial begin
      if (SLOT_W < 4)                $fatal(1, "SLOT_W must be at least 4");
      if (SLOTS < 2)                 $fatal(1, "SLOTS must be at least 2");
      if (DEPTH < 2)                 $fatal(1, "DEPTH must be at least 2");
      if ((DEPTH & (DEPTH - 1)) != 0) $fatal(1, "DEPTH must be a power of two");
   end

   logic              tick;
   logic [PW-1:0]     pos_cur;
   logic [SW-1:0]     slot_cur;
   logic              last_bit;
   logic              frame_end;
   logic [SLOT_W-1:0] word;
   logic [1:0]        push;

   tdm_rx_timing #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .PW(PW), .SW(SW)) u_timing (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk      (bclk),
      .fsync     (fsync),
      .tick      (tick),
      .pos_cur   (pos_cur),
      .slot_cur  (slot_cur),
      .last_bit  (last_bit),
      .frame_end (frame_end)
   );

   tdm_rx_shift #(.SLOT_W(SLOT_W)) u_shift (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .sdata (sdata),
      .word  (word)
   );

   tdm_rx_ctrl #(.SLOT_W(SLOT_W), .SLOTS(SLOTS), .PW(PW), .SW(SW), .DUAL(DUAL)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .glb_en    (glb_en),
      .rx_en     (rx_en),
      .two_ch    (two_ch),
      .slot_mask (slot_mask),
      .tick      (tick),
      .pos_cur   (pos_cur),
      .slot_cur  (slot_cur),
      .last_bit  (last_bit),
      .frame_end (frame_end),
      .full      (rx_full),
      .ovr_clr   (ovr_clr),
      .push      (push),
      .ovr       (ovr)
   );

   generate
      for (genvar c = 0; c < 2; c++) begin : g_ch
         if (c < NCH) begin : g_fifo
            tdm_rx_fifo #(.WIDTH(SLOT_W), .DEPTH(DEPTH), .AW(AW), .CW(CW)) u_fifo (
               .clk     (clk),
               .rst_n   (rst_n),
               .push    (push[c]),
               .din     (word),
               .pop_req (rd_en[c]),
               .wmark   (wmark),
               .dout    (rd_data[c]),
               .level   (rx_level[c]),
               .full    (rx_full[c]),
               .rdy     (rx_rdy[c])
            );
         end else begin : g_none
            assign rd_data[c]  = '0;
            assign rx_level[c] = '0;
            assign rx_full[c]  = 1'b0;
            assign rx_rdy[c]   = 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/tdm_net_rx_chk.sv
module tdm_net_rx_chk #(
   parameter int unsigned CW = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                glb_en,
   input logic                two_ch,
   input logic [CW-1:0]       wmark,
   input logic [1:0]          rd_en,
   input logic [1:0][CW-1:0]  rx_level,
   input logic [1:0]          rx_full,
   input logic [1:0]          rx_rdy,
   input logic                ovr_clr,
   input logic                ovr
);
   // R1
   off_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !glb_en |=> (rx_level[0] <= $past(rx_level[0])));

   // R6
   single_ch_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !two_ch |=> (rx_level[1] <= $past(rx_level[1])));

   // R8
   full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_full[0] && !rd_en[0]) |=> (rx_level[0] == $past(rx_level[0])));

   // R9
   ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !ovr_clr) |=> ovr);

   // R10
   level_no_loss_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en[1] |=> (rx_level[1] >= $past(rx_level[1])));

   // R11
   rdy_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rx_rdy[0] |-> ((rx_level[0] != '0) && (rx_level[0] >= wmark)));
endmodule

bind tdm_net_rx tdm_net_rx_chk #(.CW(CW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .glb_en   (glb_en),
   .two_ch   (two_ch),
   .wmark    (wmark),
   .rd_en    (rd_en),
   .rx_level (rx_level),
   .rx_full  (rx_full),
   .rx_rdy   (rx_rdy),
   .ovr_clr  (ovr_clr),
   .ovr      (ovr)
);

// File: tb/tb_tdm_net_rx.sv
module tb_tdm_net_rx;
   localparam int W  = 8;
   localparam int N  = 4;
   localparam int D  = 4;
   localparam int CW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b1, fsync = 1'b0, sdata = 1'b0;
   logic glb_en = 1'b0, rx_en = 1'b0, two_ch = 1'b0, ovr_clr = 1'b0;
   logic [N-1:0] slot_mask = '1;
   logic [CW-1:0] wmark = 3'd1;
   logic [1:0] rd_en = 2'b00;
   logic [1:0][W-1:0] rd_data;
   logic [1:0][CW-1:0] rx_level;
   logic [1:0] rx_full, rx_rdy;
   logic ovr;

   int total = 0, bad = 0;
   bit done = 0;

   always #2 clk = ~clk;

   tdm_net_rx #(.SLOT_W(W), .SLOTS(N), .DEPTH(D), .DUAL(1'b1)) dut (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .sdata(sdata),
      .glb_en(glb_en), .rx_en(rx_en), .two_ch(two_ch), .slot_mask(slot_mask),
      .wmark(wmark), .rd_en(rd_en), .rd_data(rd_data), .rx_level(rx_level),
      .rx_full(rx_full), .rx_rdy(rx_rdy), .ovr_clr(ovr_clr), .ovr(ovr)
   );

   task automatic chk(input string tag, input string what, input int got, input int exp);
      total++;
      if (got != exp) begin
         bad++;
         $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
      end
   endtask

   // behavioural reference model
   int q0[$], q1[$];
   bit m_bprev, m_run, m_sel, m_ovr;
   int m_pos, m_slot;
   logic [W-1:0] m_sr;

   always @(negedge clk) begin
      if (!rst_n) begin
         q0.delete(); q1.delete();
         m_bprev = 0; m_run = 0; m_sel = 0; m_ovr = 0;
         m_pos = 0; m_slot = 0; m_sr = '0;
      end else begin
         chk("R10", "level0", int'(rx_level[0]), q0.size());
         chk("R10", "level1", int'(rx_level[1]), q1.size());
         chk("R2", "head0", int'(rd_data[0]), q0.size() ? q0[0] : 0);
         chk("R2", "head1", int'(rd_data[1]), q1.size() ? q1[0] : 0);
         chk("R10", "full0", int'(rx_full[0]), int'(q0.size() == D));
         chk("R10", "full1", int'(rx_full[1]), int'(q1.size() == D));
         chk("R11", "rdy0", int'(rx_rdy[0]), int'(q0.size() >= ((wmark == 0) ? 1 : wmark)));
         chk("R11", "rdy1", int'(rx_rdy[1]), int'(q1.size() >= ((wmark == 0) ? 1 : wmark)));
         chk("R8", "ovr", int'(ovr), int'(m_ovr));
         begin
            bit tk, last, fend, cap, tgt, f0, f1, nsel;
            int cp, cs;
            tk = m_bprev && !bclk;
            m_bprev = bclk;
            cp = fsync ? 0 : m_pos;
            cs = fsync ? 0 : m_slot;
            if (tk) m_sr = {m_sr[W-2:0], sdata};
            last = (cp == W-1);
            fend = last && (cs == N-1);
            cap = tk && last && m_run && glb_en && slot_mask[cs];
            tgt = two_ch ? m_sel : 1'b0;
            f0 = (q0.size() == D);
            f1 = (q1.size() == D);
            if (rd_en[0] && q0.size() > 0) void'(q0.pop_front());
            if (rd_en[1] && q1.size() > 0) void'(q1.pop_front());
            if (cap && ((tgt == 0 && f0) || (tgt == 1 && f1))) m_ovr = 1;
            else begin
               if (cap && tgt == 0) q0.push_back(int'(m_sr));
               if (cap && tgt == 1) q1.push_back(int'(m_sr));
               if (ovr_clr) m_ovr = 0;
            end
            if (!glb_en) begin
               m_run = 0; m_sel = 0;
            end else if (m_run) begin
               nsel = m_sel;
               if (cap && two_ch) nsel = !m_sel;
               if (tk && fend && !rx_en) begin m_run = 0; nsel = 0; end
               m_sel = nsel;
            end else if (rx_en && tk && cp <= W-3) begin
               m_run = 1; m_sel = 0;
            end
            if (tk) begin
               if (last) begin m_pos = 0; m_slot = (cs == N-1) ? 0 : cs + 1; end
               else begin m_pos = cp + 1; m_slot = cs; end
            end
         end
      end
   end

   // one frame; optional rx_en change at (act_s, act_b)
   task automatic frame(input logic [N*W-1:0] words, input int act_s = -1,
                        input int act_b = 0, input logic act_v = 1'b0);
      for (int s = 0; s < N; s++) begin
         for (int b = 0; b < W; b++) begin
            @(posedge clk); #1;
            if (s == act_s && b == act_b) rx_en = act_v;
            bclk = 1'b0;
            fsync = (s == 0 && b == 0);
            sdata = words[W*(N-1-s) + (W-1-b)];
            @(posedge clk);
            @(posedge clk); #1;
            bclk = 1'b1;
            fsync = 1'b0;
            @(posedge clk);
         end
      end
      repeat (2) @(posedge clk);
   endtask

   task automatic read_chk(input int c, input int exp, input string tag);
      @(negedge clk);
      chk(tag, $sformatf("read fifo%0d", c), int'(rd_data[c]), exp);
      @(posedge clk); #1; rd_en[c] = 1'b1;
      @(posedge clk); #1; rd_en[c] = 1'b0;
   endtask

   task automatic lvl_chk(input int c, input int exp, input string tag);
      @(negedge clk);
      chk(tag, $sformatf("level%0d", c), int'(rx_level[c]), exp);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R10", "reset level0", int'(rx_level[0]), 0);
      chk("R9", "reset ovr", int'(ovr), 0);
      chk("R11", "reset rdy", int'(rx_rdy), 0);
      @(posedge clk); #1; rst_n = 1'b1;

      // single channel, all slots
      glb_en = 1; rx_en = 1;
      frame({8'hA1, 8'hB2, 8'hC3, 8'hD4});
      lvl_chk(0, 4, "R2");
      read_chk(0, 'hA1, "R2"); read_chk(0, 'hB2, "R2");
      read_chk(0, 'hC3, "R6"); read_chk(0, 'hD4, "R6");
      lvl_chk(1, 0, "R6");

      // mask 0101: slots 0 and 2
      slot_mask = 4'b0101;
      frame({8'h11, 8'h22, 8'h33, 8'h44});
      lvl_chk(0, 2, "R5");
      read_chk(0, 'h11, "R5"); read_chk(0, 'h33, "R5");

      // two channel alternation
      slot_mask = 4'b1111; two_ch = 1;
      frame({8'h51, 8'h62, 8'h73, 8'h84});
      read_chk(0, 'h51, "R7"); read_chk(0, 'h73, "R7");
      read_chk(1, 'h62, "R7"); read_chk(1, 'h84, "R7");
      two_ch = 0;

      // disable at slot 0: frame still completes, next frame empty
      frame({8'h01, 8'h02, 8'h03, 8'h04}, 0, 0, 1'b0);
      lvl_chk(0, 4, "R4");
      for (int i = 1; i <= 4; i++) read_chk(0, i, "R4");
      frame({8'h05, 8'h06, 8'h07, 8'h08});
      lvl_chk(0, 0, "R4");

      // late enable at position W-2: starts next slot
      frame({8'h21, 8'h31, 8'h41, 8'h51}, 1, W-2, 1'b1);
      lvl_chk(0, 2, "R3");
      read_chk(0, 'h41, "R3"); read_chk(0, 'h51, "R3");
      frame({8'h61, 8'h62, 8'h63, 8'h64}, 0, 0, 1'b0);
      for (int i = 1; i <= 4; i++) read_chk(0, 'h60 + i, "R4");
      // early enable at position W-3: slot included
      frame({8'h71, 8'h72, 8'h73, 8'h74}, 1, W-3, 1'b1);
      lvl_chk(0, 3, "R3");
      read_chk(0, 'h72, "R3"); read_chk(0, 'h73, "R3"); read_chk(0, 'h74, "R3");

      // two channel, odd mask across frames
      two_ch = 1; slot_mask = 4'b0111;
      frame({8'hA0, 8'hA1, 8'hA2, 8'hFF});
      frame({8'hB0, 8'hB1, 8'hB2, 8'hFF});
      read_chk(0, 'hA0, "R7"); read_chk(0, 'hA2, "R7"); read_chk(0, 'hB1, "R7");
      read_chk(1, 'hA1, "R7"); read_chk(1, 'hB0, "R7"); read_chk(1, 'hB2, "R7");
      frame({8'hC0, 8'hC1, 8'hC2, 8'hFF});
      read_chk(0, 'hC0, "R7"); read_chk(0, 'hC2, "R7"); read_chk(1, 'hC1, "R7");
      @(posedge clk); #1; glb_en = 0;
      @(posedge clk); #1; glb_en = 1;
      frame({8'hE0, 8'hE1, 8'hE2, 8'hFF});
      read_chk(0, 'hE0, "R7"); read_chk(1, 'hE1, "R7"); read_chk(0, 'hE2, "R7");
      two_ch = 0; slot_mask = 4'b1111;

      // global disable
      @(posedge clk); #1; glb_en = 0;
      frame({8'h91, 8'h92, 8'h93, 8'h94});
      lvl_chk(0, 0, "R1");
      @(posedge clk); #1; glb_en = 1;

      // overrun
      frame({8'hD0, 8'hD1, 8'hD2, 8'hD3});
      frame({8'hE5, 8'hE6, 8'hE7, 8'hE8});
      lvl_chk(0, 4, "R8");
      @(negedge clk); chk("R8", "ovr set", int'(ovr), 1);
      for (int i = 0; i < 4; i++) read_chk(0, 'hD0 + i, "R8");
      @(posedge clk); #1; ovr_clr = 1;
      @(posedge clk); #1; ovr_clr = 0;
      @(negedge clk); chk("R9", "ovr cleared", int'(ovr), 0);

      // empty read ignored
      @(posedge clk); #1; rd_en[0] = 1;
      @(posedge clk); #1; rd_en[0] = 0;
      lvl_chk(0, 0, "R10");

      // watermark
      wmark = 3; slot_mask = 4'b0011;
      frame({8'h12, 8'h34, 8'h56, 8'h78});
      @(negedge clk); chk("R11", "rdy below", int'(rx_rdy[0]), 0);
      slot_mask = 4'b0001;
      frame({8'h9A, 8'hBC, 8'hDE, 8'hF0});
      @(negedge clk); chk("R11", "rdy at mark", int'(rx_rdy[0]), 1);

      repeat (4) @(posedge clk);
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: got hang expected completion");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule